// File: doc/BRIEF.md
# Multichannel Simultaneous-Sampling Conversion Sequencer

This block is the digital core of a converter that samples up to eight channels at the same instant and then converts them one after another on an external clock. A channel-enable mask is loaded over a shared parallel bus with chip-select and write strobes. The mask is held in a staging register and only becomes the working mask when the start strobe falls. While the start strobe is low the channels acquire. On its rising edge the block freezes one digitised sample per channel, taken from a wide input port. It then produces one 14-bit result for each enabled channel, lowest channel first.

Results appear at a fixed cadence counted in clock cycles. A one-cycle active-low flag marks each new result. A second active-low flag marks the final one and stays low until the next acquisition begins. The host reads results back over a 14-bit bus. Each completed read pulse moves on to the next stored result, and the pointer stops on the last result. Shutdown keeps the configuration intact and blocks new sequences while it is active.

Top module: `simsamp_seq`

## Requirements
- R1: After reset all eight channels are enabled, `eoc_n` and `eolc_n` are high and `data_oe` is low.
- R2: On a rising edge of `wr_n` sampled while `cs_n` is low, `cfg_in` is captured into the staging mask. Bit i set to 1 enables channel i and 0 disables it. A `wr_n` rising edge while `cs_n` is high is ignored.
- R3: The staging mask becomes the working mask only at a falling edge of `start_n`. A write during a running sequence leaves that sequence unchanged.
- R4: `sample_in` (channel c in bits c*14+13..c*14) is frozen on the clock edge that first sees `start_n` high. Counting that edge as 0, result k is announced on edge 17+3k by `eoc_n` being low for exactly one cycle.
- R5: Exactly one result is produced per enabled channel, in ascending channel order.
- R6: `eolc_n` goes low together with the last result's `eoc_n` pulse, which is edge 38 with all eight channels enabled. It stays low until the next `start_n` falling edge.
- R7: `data_oe` is high only while `rd_n` and `cs_n` are both low. Otherwise `data_out` is zero.
- R8: Each `rd_n` low pulse with `cs_n` low presents the next result: the first pulse after a sequence shows result 0. The read pointer returns to result 0 at each `start_n` falling edge. Reads past the last result return the last result again.
- R9: With an all-zero working mask a start produces no `eoc_n` pulse, and `eolc_n` stays high.
- R10: While `shutdown` is high, `start_n` edges are ignored. Shutdown never alters the staging or working mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Bus chip select, active low |
| wr_n | input | 1 | Configuration write strobe, captured on its rising edge |
| rd_n | input | 1 | Result read strobe, active low |
| start_n | input | 1 | Acquire while low; conversion starts on its rising edge |
| shutdown | input | 1 | Blocks start edges, keeps configuration |
| cfg_in | input | 8 | Low bus bits driven by the host (channel mask) |
| sample_in | input | 112 | Digitised sample per channel, 14 bits each |
| data_out | output | 14 | Result bus value |
| data_oe | output | 1 | Result bus drive enable |
| eoc_n | output | 1 | One-cycle low pulse per result |
| eolc_n | output | 1 | Low once the last result is ready |

## Verification
On every cycle, the embedded assertions check several properties. `eoc_n` never stays low two cycles in a row. `eolc_n` only falls on a result pulse. An all-zero mask never yields a pulse. The working mask moves only on an accepted start fall, and the staging mask only on a bus write. The read pointer stays in range and moves only on a read or a new start. The bench scenarios are needed for the rest: the exact 17+3k cadence, ascending channel order with sparse masks, sample freezing at the rising start edge, the mid-sequence write, read-pointer saturation, and the way shutdown blocks starts while keeping the mask.

// File: rtl/simsamp_pkg.sv
// Shared defaults for the simultaneous-sampling sequencer.
// Assumes channel count does not exceed the result width (mask rides low bus bits).
package simsamp_pkg;
    localparam int CH_N      = 8;   // channels
    localparam int RES_W     = 14;  // result width
    localparam int FIRST_LAT = 17;  // edges from start rise to first result
    localparam int GAP       = 3;   // edges between results
endpackage

// File: rtl/simsamp_cfg.sv
// Channel mask store: staging register written from the bus, working register
// loaded from staging on an accepted start fall.
// Assumes write/load pulses are single-cycle, already qualified by the top.
module simsamp_cfg #(
    parameter int NCH = simsamp_pkg::CH_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_cap,
    input  logic           load,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] active
);
    logic [NCH-1:0] pend;

    // Capture host writes and promote them at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '1;
            active <= '1;
        end else begin
            if (wr_cap) pend <= din;
            if (load) active <= pend;
        end
    end

    p_active_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(load))
        else $error("working mask moved without start fall");

    p_pend_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pend) |-> $past(wr_cap))
        else $error("staging mask moved without bus write");
endmodule

// File: rtl/simsamp_sched.sv
// Conversion scheduler: counts edges from the start rise, announces one result
// per enabled channel at FIRST + GAP*k, lowest channel first.
// Assumes go_fall and go_rise are never high together.
module simsamp_sched #(
    parameter int NCH   = simsamp_pkg::CH_N,
    parameter int FIRST = simsamp_pkg::FIRST_LAT,
    parameter int STEP  = simsamp_pkg::GAP,
    localparam int IW   = $clog2(NCH),
    localparam int SW   = $clog2(NCH + 1),
    localparam int CW   = $clog2(FIRST + STEP * NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_fall,
    input  logic           go_rise,
    input  logic [NCH-1:0] mask,
    output logic           emit,
    output logic [IW-1:0]  emit_slot,
    output logic [IW-1:0]  emit_ch,
    output logic [SW-1:0]  nres,
    output logic           eoc_n,
    output logic           eolc_n
);
    logic          running;
    logic [CW-1:0] cnt;
    logic [SW-1:0] slot;
    logic [IW:0]   from;
    logic          last;
    int            pick;

    // Lowest enabled channel at or above the search start.
    always_comb begin
        pick = NCH;
        for (int i = NCH - 1; i >= 0; i--)
            if (mask[i] && i >= int'(from)) pick = i;
    end

    // Slot timing and end-of-sequence detection.
    always_comb begin
        nres      = SW'($countones(mask));
        emit      = running && (int'(cnt) + 1 == FIRST + STEP * int'(slot));
        last      = (int'(slot) + 1 == int'(nres));
        emit_slot = slot[IW-1:0];
        emit_ch   = IW'(pick);
    end

    // Sequence state and the two result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            slot    <= '0;
            from    <= '0;
            eoc_n   <= 1'b1;
            eolc_n  <= 1'b1;
        end else begin
            eoc_n <= 1'b1;
            if (go_fall) begin
                running <= 1'b0;
                slot    <= '0;
                eolc_n  <= 1'b1;
            end else if (go_rise) begin
                running <= (mask != '0);
                cnt     <= '0;
                slot    <= '0;
                from    <= '0;
                eolc_n  <= 1'b1;
            end else if (running) begin
                cnt <= cnt + CW'(1);
                if (emit) begin
                    eoc_n <= 1'b0;
                    slot  <= slot + SW'(1);
                    from  <= (IW + 1)'(pick + 1);
                    if (last) begin
                        eolc_n  <= 1'b0;
                        running <= 1'b0;
                    end
                end
            end
        end
    end

    p_eoc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n |=> eoc_n)
        else $error("result flag held low too long");

    p_eolc_on_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eolc_n) |-> !eoc_n)
        else $error("last flag fell without a result");

    p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= nres)
        else $error("more results than enabled channels");

    p_empty_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (eoc_n && eolc_n))
        else $error("result flagged with empty mask");
endmodule

// File: rtl/simsamp_rbuf.sv
// Result store: freezes samples at start rise, files each announced result by
// slot, and serves them through a saturating read pointer.
// Assumes emit_slot is below the enabled-channel count.
module simsamp_rbuf #(
    parameter int NCH = simsamp_pkg::CH_N,
    parameter int RW  = simsamp_pkg::RES_W,
    localparam int IW = $clog2(NCH),
    localparam int SW = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_en,
    input  logic [NCH*RW-1:0] samples,
    input  logic              emit,
    input  logic [IW-1:0]     emit_slot,
    input  logic [IW-1:0]     emit_ch,
    input  logic              ptr_clr,
    input  logic              ptr_adv,
    input  logic [SW-1:0]     nres,
    output logic [RW-1:0]     rd_data
);
    logic [RW-1:0] snap [NCH];
    logic [RW-1:0] res  [NCH];
    logic [IW-1:0] rptr;

    for (genvar c = 0; c < NCH; c++) begin : g_snap
        // Hold channel c's sample from the start rise.
        always_ff @(posedge clk) begin
            if (!rst_n) snap[c] <= '0;
            else if (snap_en) snap[c] <= samples[c*RW +: RW];
        end
    end

    // File each result under its sequence slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) res[i] <= '0;
        end else if (emit) begin
            res[emit_slot] <= snap[emit_ch];
        end
    end

    // Read pointer: restart at start, advance per read, stop on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) rptr <= '0;
        else if (ptr_clr) rptr <= '0;
        else if (ptr_adv && (int'(rptr) + 1 < int'(nres))) rptr <= rptr + IW'(1);
    end

    assign rd_data = res[rptr];

    p_rptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nres != '0) |-> (int'(rptr) < int'(nres)))
        else $error("read pointer past last result");

    p_rptr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rptr) |-> $past(ptr_clr || ptr_adv))
        else $error("read pointer moved without cause");
endmodule

// File: rtl/simsamp_seq.sv
// Top of the simultaneous-sampling conversion sequencer. Detects strobe edges
// on the conversion clock, gates starts with shutdown, and drives the result bus.
// Assumes all strobes are synchronous to clk.
module simsamp_seq #(
    parameter int NCH   = simsamp_pkg::CH_N,
    parameter int RW    = simsamp_pkg::RES_W,
    parameter int FIRST = simsamp_pkg::FIRST_LAT,
    parameter int STEP  = simsamp_pkg::GAP,
    localparam int IW   = $clog2(NCH),
    localparam int SW   = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              start_n,
    input  logic              shutdown,
    input  logic [NCH-1:0]    cfg_in,
    input  logic [NCH*RW-1:0] sample_in,
    output logic [RW-1:0]     data_out,
    output logic              data_oe,
    output logic              eoc_n,
    output logic              eolc_n
);
    logic          start_q, wr_q, rd_q;
    logic          go_fall, go_rise, wr_cap, rd_done;
    logic [NCH-1:0] active;
    logic          emit;
    logic [IW-1:0] emit_slot, emit_ch;
    logic [SW-1:0] nres;
    logic [RW-1:0] rd_data;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b1;
            wr_q    <= 1'b1;
            rd_q    <= 1'b1;
        end else begin
            start_q <= start_n;
            wr_q    <= wr_n;
            rd_q    <= rd_n;
        end
    end

    // Qualified single-cycle events.
    always_comb begin
        go_fall = start_q && !start_n && !shutdown;
        go_rise = !start_q && start_n && !shutdown;
        wr_cap  = !wr_q && wr_n && !cs_n;
        rd_done = !rd_q && rd_n && !cs_n;
        data_oe = !rd_n && !cs_n;
        data_out = data_oe ? rd_data : '0;
    end

    simsamp_cfg #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_cap(wr_cap), .load(go_fall),
        .din(cfg_in), .active(active)
    );

    simsamp_sched #(.NCH(NCH), .FIRST(FIRST), .STEP(STEP)) u_sched (
        .clk(clk), .rst_n(rst_n), .go_fall(go_fall), .go_rise(go_rise),
        .mask(active), .emit(emit), .emit_slot(emit_slot), .emit_ch(emit_ch),
        .nres(nres), .eoc_n(eoc_n), .eolc_n(eolc_n)
    );

    simsamp_rbuf #(.NCH(NCH), .RW(RW)) u_rbuf (
        .clk(clk), .rst_n(rst_n), .snap_en(go_rise), .samples(sample_in),
        .emit(emit), .emit_slot(emit_slot), .emit_ch(emit_ch),
        .ptr_clr(go_fall), .ptr_adv(rd_done), .nres(nres), .rd_data(rd_data)
    );
endmodule

// File: tb/simsamp_seq_test.sv
// Bench for simsamp_seq: a table of masks walked by one loop, then directed
// tests for reset, ignored writes, mid-sequence writes, bus idle, empty mask, shutdown.
module simsamp_seq_test;
    localparam int NCH = 8;
    localparam int RW  = 14;
    localparam time TCK = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, start_n = 1'b1, shutdown = 1'b0;
    logic [NCH-1:0] cfg_in = '0;
    logic [NCH*RW-1:0] sample_in = '0;
    logic [RW-1:0] data_out;
    logic data_oe, eoc_n, eolc_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    simsamp_seq uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .start_n(start_n), .shutdown(shutdown), .cfg_in(cfg_in),
        .sample_in(sample_in), .data_out(data_out), .data_oe(data_oe),
        .eoc_n(eoc_n), .eolc_n(eolc_n)
    );

    localparam int NVEC = 5;
    localparam logic [7:0]  VMASK [NVEC] = '{8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C};
    localparam logic [13:0] VBASE [NVEC] = '{14'h0100, 14'h1234, 14'h3FF0, 14'h0A0A, 14'h2001};

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [13:0] sval(input logic [13:0] base, input int c);
        return base + 14'(c * 37);
    endfunction

    task automatic bus_write(input logic [7:0] m, input logic sel_n);
        @(negedge clk); cs_n = sel_n; wr_n = 1'b0; cfg_in = m;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic read_one(output logic [13:0] d, output logic oe);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); d = data_out; oe = data_oe;
        rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    // One start pulse with timing, order and read-back checks.
    task automatic run_seq(input logic [7:0] expm, input logic [13:0] base,
                           input bit midw, input logic [7:0] midm);
        int chans[8];
        int nexp = 0;
        int seen = 0;
        int eolc_at = -1;
        logic [13:0] d;
        logic oe;
        for (int c = 0; c < NCH; c++) begin
            sample_in[c*RW +: RW] = sval(base, c);
            if (expm[c]) begin chans[nexp] = c; nexp++; end
        end
        @(negedge clk); start_n = 1'b0;
        @(negedge clk); start_n = 1'b1;
        @(posedge clk);
        for (int j = 1; j <= 45; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (!eoc_n) begin
                chk("R4 result pulse edge", j, 17 + 3 * seen);
                seen++;
            end
            if (!eolc_n && eolc_at < 0) eolc_at = j;
            if (j == 1) sample_in = '1;   // R4: later input changes must not leak in
            if (midw) begin
                if (j == 5) begin cs_n = 1'b0; wr_n = 1'b0; cfg_in = midm; end
                if (j == 6) wr_n = 1'b1;
                if (j == 7) cs_n = 1'b1;
            end
        end
        chk("R5 result count", seen, nexp);
        chk("R6/R9 last flag edge", eolc_at, (nexp > 0) ? 17 + 3 * (nexp - 1) : -1);
        if (nexp > 0) begin
            for (int k = 0; k <= nexp; k++) begin
                int ix = (k < nexp) ? k : nexp - 1;
                read_one(d, oe);
                chk("R8 read value order", int'(d), int'(sval(base, chans[ix])));
                chk("R7 drive while reading", int'(oe), 1);
            end
        end
    endtask

    initial begin
        logic [13:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 eoc_n after reset", int'(eoc_n), 1);
        chk("R1 eolc_n after reset", int'(eolc_n), 1);
        chk("R1/R7 bus idle after reset", int'(data_oe), 0);
        // R1: default mask is all eight channels.
        run_seq(8'hFF, 14'h0777, 1'b0, 8'h00);

        // R2 R4 R5 R6 R8: table walk.
        for (int v = 0; v < NVEC; v++) begin
            bus_write(VMASK[v], 1'b0);
            run_seq(VMASK[v], VBASE[v], 1'b0, 8'h00);
        end

        // R2: write with cs_n high ignored; previous mask 0x3C still applies.
        bus_write(8'h01, 1'b1);
        run_seq(8'h3C, 14'h0055, 1'b0, 8'h00);

        // R3: write mid-sequence; current run keeps 0xFF, next run uses 0x02.
        bus_write(8'hFF, 1'b0);
        run_seq(8'hFF, 14'h0300, 1'b1, 8'h02);
        run_seq(8'h02, 14'h0400, 1'b0, 8'h00);

        // R7: read strobe with chip select high leaves the bus idle.
        @(negedge clk); rd_n = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        chk("R7 oe with cs_n high", int'(data_oe), 0);
        chk("R7 data with cs_n high", int'(data_out), 0);
        rd_n = 1'b1;

        // R9: empty mask.
        bus_write(8'h00, 1'b0);
        run_seq(8'h00, 14'h0001, 1'b0, 8'h00);

        // R10: shutdown blocks starts and keeps the staged mask.
        bus_write(8'h81, 1'b0);
        @(negedge clk); shutdown = 1'b1;
        run_seq(8'h00, 14'h0002, 1'b0, 8'h00);
        @(negedge clk); shutdown = 1'b0;
        run_seq(8'h81, 14'h0600, 1'b0, 8'h00);

        // R8: a new start rewinds the read pointer to result 0.
        read_one(d, oe);
        chk("R8 read after extra reads stays last", int'(d), int'(sval(14'h0600, 7)));
        run_seq(8'h81, 14'h0700, 1'b0, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R4 sequence): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule